// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns one bus request from a small processor core into a complete cycle on a shared 16-bit address/data bus. A request carries an operation (read, write or interrupt acknowledge), a memory or I/O selector, a 20-bit address, a byte or word width, a two-bit segment class and, for writes, the data. The sequencer accepts the request while idle. It then walks the fixed state order T1, T2, T3, any number of wait states, and T4, and returns to idle.

In T1 the shared lines present the address. The upper four lines carry the top address bits, and the byte-lane pair {bheN, A0} gives the transfer size. A latch-enable output marks T1 so that outside logic can capture the address. From T2 onward the upper lines show a status word, and the shared lines carry write data or are released for read data. One of three active-low strobes marks the data phase. A READY input stretches the cycle with wait states. Read data is captured on the last data-phase edge and returned with a one-cycle done pulse. A memory/IO line reports the type of the running cycle and holds that value after the cycle ends.

Top module: `adbus_seq`

## Requirements
- R1: `reqReady` is high only while idle. A request with `reqValid` high is accepted at that edge. The next cycles are T1, T2, T3, zero or more wait states, T4, then idle, and `aleOut` is high in T1 and low in every other cycle.
- R2: In T1 of a read or write cycle, `adOe` is 1 and `adOut` equals address bits 15..0.
- R3: In T1, `upperOut` equals address bits 19..16 for a memory read or write, and 0 for an I/O cycle or an interrupt acknowledge.
- R4: In T1, the pair {`bheN`, `adOut[0]`} is 00 for a word at an even address, 10 for a byte at an even address and 01 for a byte at an odd address. In T1 of an interrupt acknowledge `bheN` is 0. In every other cycle `bheN` is 1.
- R5: From T2 through T4, `upperOut` is {0, ie, seg}. Here ie is `intEnable` as sampled at the previous clock edge, and seg is the segment class: 00 alternate, 01 stack, 10 code/none, 11 data.
- R6: Operation codes are 00 read, 01 write and 10 interrupt acknowledge. The matching strobe `rdN`, `wrN` or `intaN` is 0 in T2, T3 and wait states, and all three strobes are 1 otherwise.
- R7: In a read, `adOe` is 0 from T2 through T4. In an interrupt acknowledge, `adOe` is 0 for the whole cycle. `adOe` is never 1 while `rdN` is 0.
- R8: In a write, `adOe` is 1 and `adOut` equals the request's write data from T2 through T4.
- R9: `ready` is sampled at the end of T3 and at the end of each wait state. A 0 there inserts a wait state in which the strobe stays asserted, and a 1 leads to T4.
- R10: `doneOut` is high for exactly the T4 cycle. In a read, `rdata` then holds the value `adIn` had at the edge that ended the last T3 or wait state.
- R11: `memIo` takes the request's memory/IO bit (1 memory, 0 I/O) at acceptance and keeps it until the next acceptance.
- R12: Request inputs presented while a cycle is in progress have no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqKind | input | 2 | Operation: 00 read, 01 write, 10 interrupt acknowledge |
| reqIsMem | input | 1 | 1 memory, 0 I/O |
| reqAddr | input | 20 | Byte address |
| reqWord | input | 1 | 1 word transfer, 0 byte transfer |
| reqSeg | input | 2 | Segment class for status |
| reqWdata | input | 16 | Write data |
| intEnable | input | 1 | Interrupt-enable flag shown in status |
| ready | input | 1 | Transfer-complete acknowledge from the device |
| adIn | input | 16 | Shared lines as seen from the bus |
| reqReady | output | 1 | Idle, request can be accepted |
| adOut | output | 16 | Value driven onto the shared lines |
| adOe | output | 1 | Output enable for the shared lines |
| upperOut | output | 4 | Upper address / status lines |
| bheN | output | 1 | Bus-high-enable, active low |
| aleOut | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| intaN | output | 1 | Interrupt acknowledge strobe, active low |
| memIo | output | 1 | Memory (1) or I/O (0) cycle type |
| doneOut | output | 1 | One-cycle completion pulse in T4 |
| rdata | output | 16 | Captured read data |

## Verification
A wrong state register shows at the ports in the very next cycle. Every T-state has its own combination of `aleOut`, the strobes, `adOe` and `doneOut`, so a skipped or repeated state breaks that combination at once. A wait-state decision taken on the wrong edge shifts `doneOut` by one cycle. The changing `adIn` pattern makes a capture on the wrong edge return a different `rdata` value. A stale request or status register shows up as a wrong `upperOut`, `bheN` or `adOut` value in the same cycle the phase starts.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  localparam int ADDR_W  = 20;
  localparam int DATA_W  = 16;
  localparam int UPPER_W = ADDR_W - DATA_W;
  localparam int SEG_W   = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_T3, ST_TW, ST_T4
  } busState_e;

  localparam logic [1:0] K_READ  = 2'b00;
  localparam logic [1:0] K_WRITE = 2'b01;
  localparam logic [1:0] K_INTA  = 2'b10;

  typedef struct packed {
    logic latchReq;
    logic addrPhase;
    logic addrDrive;
    logic statPhase;
    logic dataDrive;
    logic capture;
  } dpStrobe_t;
endpackage

// File: rtl/adbus_ctrl.sv
module adbus_ctrl
  import adbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       ready,
  input  logic [1:0] curKind,
  output dpStrobe_t  stb,
  output logic       reqReady,
  output logic       aleOut,
  output logic       rdN,
  output logic       wrN,
  output logic       intaN,
  output logic       doneOut
);
  busState_e stState, stNext;

  always_comb begin
    stNext = stState;
    unique case (stState)
      ST_IDLE: if (reqValid) stNext = ST_T1;
      ST_T1:   stNext = ST_T2;
      ST_T2:   stNext = ST_T3;
      ST_T3,
      ST_TW:   stNext = ready ? ST_T4 : ST_TW;
      ST_T4:   stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stState <= ST_IDLE;
    else       stState <= stNext;
  end

  logic strobeWin, dataWin, lastData;
  assign strobeWin = (stState == ST_T2) || (stState == ST_T3) || (stState == ST_TW);
  assign dataWin   = strobeWin || (stState == ST_T4);
  assign lastData  = ((stState == ST_T3) || (stState == ST_TW)) && ready;

  assign reqReady = (stState == ST_IDLE);
  assign aleOut   = (stState == ST_T1);
  assign doneOut  = (stState == ST_T4);
  assign rdN      = !(strobeWin && curKind == K_READ);
  assign wrN      = !(strobeWin && curKind == K_WRITE);
  assign intaN    = !(strobeWin && curKind == K_INTA);

  always_comb begin
    stb.latchReq  = (stState == ST_IDLE) && reqValid;
    stb.addrPhase = (stState == ST_T1);
    stb.addrDrive = (stState == ST_T1) && (curKind != K_INTA);
    stb.statPhase = dataWin;
    stb.dataDrive = dataWin && (curKind == K_WRITE);
    stb.capture   = lastData && (curKind == K_READ);
  end

  // R1
  ale_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    aleOut |=> !aleOut);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({!rdN, !wrN, !intaN}));
  // R9
  wait_insert_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stState == ST_T3 || stState == ST_TW) && !ready) |=> (stState == ST_TW));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> (!doneOut && reqReady));
endmodule

// File: rtl/adbus_dp.sv
module adbus_dp
  import adbus_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic [1:0]         reqKind,
  input  logic               reqIsMem,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqWord,
  input  logic [SEG_W-1:0]   reqSeg,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic               intEnable,
  input  logic [DATA_W-1:0]  adIn,
  output logic [1:0]         curKind,
  output logic [DATA_W-1:0]  adOut,
  output logic               adOe,
  output logic [UPPER_W-1:0] upperOut,
  output logic               bheN,
  output logic               memIo,
  output logic [DATA_W-1:0]  rdata
);
  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        kindQ;
  logic              memQ, wordQ, ieQ;
  logic [SEG_W-1:0]  segQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      kindQ  <= K_READ;
      memQ   <= 1'b0;
      wordQ  <= 1'b0;
      segQ   <= '0;
      wdataQ <= '0;
      memIo  <= 1'b0;
      ieQ    <= 1'b0;
      rdata  <= '0;
    end else begin
      ieQ <= intEnable;
      if (stb.latchReq) begin
        addrQ  <= reqAddr;
        kindQ  <= reqKind;
        memQ   <= reqIsMem;
        wordQ  <= reqWord;
        segQ   <= reqSeg;
        wdataQ <= reqWdata;
        memIo  <= reqIsMem;
      end
      if (stb.capture) rdata <= adIn;
    end
  end

  assign curKind = kindQ;

  logic [UPPER_W-1:0] statusWord;
  assign statusWord = {1'b0, ieQ, segQ};

  always_comb begin
    adOe  = stb.addrDrive || stb.dataDrive;
    adOut = '0;
    if (stb.addrDrive)      adOut = addrQ[DATA_W-1:0];
    else if (stb.dataDrive) adOut = wdataQ;
  end

  always_comb begin
    upperOut = '0;
    if (stb.addrPhase)
      upperOut = (memQ && kindQ != K_INTA) ? addrQ[ADDR_W-1:DATA_W] : '0;
    else if (stb.statPhase)
      upperOut = statusWord;
  end

  always_comb begin
    bheN = 1'b1;
    if (stb.addrPhase)
      bheN = (kindQ == K_INTA) ? 1'b0 : (wordQ ? 1'b0 : !addrQ[0]);
  end

  // R11
  mio_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchReq |=> $stable(memIo));
  // R3
  io_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.addrPhase && !memQ) |-> (upperOut == '0));
endmodule

// File: rtl/adbus_seq.sv
module adbus_seq
  import adbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  input  logic        reqIsMem,
  input  logic [19:0] reqAddr,
  input  logic        reqWord,
  input  logic [1:0]  reqSeg,
  input  logic [15:0] reqWdata,
  input  logic        intEnable,
  input  logic        ready,
  input  logic [15:0] adIn,
  output logic        reqReady,
  output logic [15:0] adOut,
  output logic        adOe,
  output logic [3:0]  upperOut,
  output logic        bheN,
  output logic        aleOut,
  output logic        rdN,
  output logic        wrN,
  output logic        intaN,
  output logic        memIo,
  output logic        doneOut,
  output logic [15:0] rdata
);
  dpStrobe_t  stb;
  logic [1:0] curKind;

  adbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ready(ready),
    .curKind(curKind), .stb(stb), .reqReady(reqReady), .aleOut(aleOut),
    .rdN(rdN), .wrN(wrN), .intaN(intaN), .doneOut(doneOut)
  );

  adbus_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqKind(reqKind),
    .reqIsMem(reqIsMem), .reqAddr(reqAddr), .reqWord(reqWord),
    .reqSeg(reqSeg), .reqWdata(reqWdata), .intEnable(intEnable),
    .adIn(adIn), .curKind(curKind), .adOut(adOut), .adOe(adOe),
    .upperOut(upperOut), .bheN(bheN), .memIo(memIo), .rdata(rdata)
  );

  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe);
endmodule

// File: tb/sim_adbus_seq.sv
`timescale 1ns/1ps
module sim_adbus_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqIsMem = 1'b0, reqWord = 1'b0;
  logic [1:0] reqKind = 2'b00, reqSeg = 2'b00;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0, adIn = '0;
  logic intEnable = 1'b0, ready = 1'b1;
  logic reqReady, adOe, bheN, aleOut, rdN, wrN, intaN, memIo, doneOut;
  logic [15:0] adOut, rdata;
  logic [3:0] upperOut;

  int nChecks = 0, nFails = 0, cycN = 0;
  bit finished = 0;

  // model state
  int ph = 0;  // 0 idle 1 T1 2 T2 3 T3 4 TW 5 T4
  logic [19:0] addrE; logic [1:0] kindE, segE; logic memE, wordE, mioE, ieE;
  logic [15:0] wdataE, rdataE;

  always #4 clk = ~clk;

  adbus_seq u0 (.*);

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", tag, what, cycN, act, exp);
    end
  endtask

  task automatic compare();
    bit strobeWin = (ph == 2 || ph == 3 || ph == 4);
    bit dataWin = strobeWin || ph == 5;
    int expOe, expUp, expBhe;
    string stTag = (ph == 4) ? "R9" : "R6";
    chk((ph == 0) ? "R1" : "R12", "reqReady", reqReady, ph == 0);
    chk("R1", "aleOut", aleOut, ph == 1);
    chk("R10", "doneOut", doneOut, ph == 5);
    chk("R11", "memIo", memIo, mioE);
    chk(stTag, "rdN", rdN, !(strobeWin && kindE == 2'b00));
    chk(stTag, "wrN", wrN, !(strobeWin && kindE == 2'b01));
    chk(stTag, "intaN", intaN, !(strobeWin && kindE == 2'b10));
    expOe = (ph == 1 && kindE != 2'b10) || (dataWin && kindE == 2'b01);
    chk((kindE == 2'b01 && dataWin) ? "R8" : (ph == 1 ? "R2" : "R7"), "adOe", adOe, expOe);
    if (expOe && ph == 1) chk("R2", "adOut", adOut, addrE[15:0]);
    if (expOe && ph != 1) chk("R8", "adOut", adOut, wdataE);
    if (ph == 1) expUp = (memE && kindE != 2'b10) ? addrE[19:16] : 0;
    else if (dataWin) expUp = {1'b0, ieE, segE};
    else expUp = 0;
    chk(dataWin ? "R5" : "R3", "upperOut", upperOut, expUp);
    if (ph == 1) expBhe = (kindE == 2'b10 || wordE) ? 0 : !addrE[0];
    else expBhe = 1;
    chk("R4", "bheN", bheN, expBhe);
    if (ph == 1 && kindE != 2'b10) chk("R4", "A0", adOut[0], addrE[0]);
    if (ph == 5 && kindE == 2'b00) chk("R10", "rdata", rdata, rdataE);
  endtask

  task automatic step();
    case (ph)
      0: if (reqValid) begin
           addrE = reqAddr; kindE = reqKind; memE = reqIsMem; wordE = reqWord;
           segE = reqSeg; wdataE = reqWdata; mioE = reqIsMem; ph = 1;
         end
      1: ph = 2;
      2: ph = 3;
      3, 4: if (ready) begin
              if (kindE == 2'b00) rdataE = adIn;
              ph = 5;
            end else ph = 4;
      default: ph = 0;
    endcase
    ieE = intEnable;
  endtask

  task automatic cyc();
    adIn = 16'hA000 ^ 16'(cycN * 37);
    intEnable = cycN[1];
    #1 compare();
    step();
    cycN++;
    @(negedge clk);
  endtask

  task automatic txn(logic [1:0] k, logic m, logic [19:0] a, logic w,
                     logic [1:0] s, logic [15:0] d, int waits, bit poke);
    bit accepted = 0;
    reqValid = 1; reqKind = k; reqIsMem = m; reqAddr = a; reqWord = w;
    reqSeg = s; reqWdata = d;
    while (!accepted || ph != 0) begin
      if (accepted && poke) begin  // R12 new fields while busy
        reqValid = 1; reqKind = ~k; reqIsMem = ~m; reqAddr = ~a;
        reqWord = ~w; reqSeg = ~s; reqWdata = ~d;
      end else if (accepted) reqValid = 0;
      ready = !((ph == 3 || ph == 4) && waits > 0);
      if ((ph == 3 || ph == 4) && waits > 0) waits--;
      if (ph == 0 && reqValid) accepted = 1;
      cyc();
      if (poke && ph == 5) reqValid = 0;
    end
    reqValid = 0; ready = 1;
    cyc();
  endtask

  initial begin
    addrE = '0; kindE = 2'b00; segE = '0; memE = 0; wordE = 0; mioE = 0;
    ieE = 0; wdataE = '0; rdataE = '0;
    @(negedge clk);
    #1 compare();  // reset state
    @(negedge clk);
    rstN = 1'b1;
    cyc(); cyc();
    txn(2'b00, 1, 20'h3A2B4, 1, 2'b11, 16'h0000, 0, 0);  // mem word read
    txn(2'b01, 0, 20'h000F1, 0, 2'b10, 16'h5AC3, 2, 0);  // io byte odd write, waits
    txn(2'b10, 1, 20'h00000, 0, 2'b00, 16'h0000, 1, 0);  // interrupt ack
    txn(2'b01, 1, 20'hF0010, 0, 2'b01, 16'h1357, 0, 1);  // mem byte even write, busy poke
    txn(2'b00, 1, 20'h85557, 0, 2'b00, 16'h0000, 3, 1);  // mem byte odd read, waits
    txn(2'b00, 0, 20'h00040, 1, 2'b10, 16'h0000, 0, 0);  // io word read
    cyc(); cyc();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule